// File: doc/BRIEF.md
# Processor Prefix Address Remapper

This block turns a real address issued by one processor into the absolute address used to reach main storage. It swaps two regions: the low window that starts at address zero, and the processor's own prefix area named by its prefix register. A real address inside the low window goes to the prefix area. A real address inside the prefix area goes to the low window. Every other address passes through unchanged.

The block has two architecture modes. In the narrow mode the window and the prefix area are 4 KB blocks on 4 KB boundaries. In the wide mode they are 8 KB blocks on 8 KB boundaries. On a change from narrow to wide, the stored prefix loses its lowest 4 KB-granular bit so that it stays aligned.

The prefix is written through a write port and can be read back at any time. Each translation is registered: the result appears one cycle after the request, together with a valid flag.

Top module: `prefix_remap`

## Requirements
- R1: A valid request whose address lies in the low window (below 4 KB in narrow mode, below 8 KB in wide mode) produces the prefix address plus the offset within the window.
- R2: A valid request whose address lies in the prefix area (the window-sized block starting at the prefix) produces the offset within the area, placed at address zero.
- R3: A valid request whose address lies in neither region produces the same address unchanged.
- R4: In narrow mode a prefix write keeps only address bits 63..12. Bits 11..0 are ignored and always read back as zero.
- R5: In wide mode a prefix write also clears bit 12. A write in the same cycle as a switch to wide mode is aligned to the wide mode.
- R6: When the mode changes from narrow to wide and no write occurs, bit 12 of the stored prefix is cleared. A change from wide to narrow leaves the prefix unchanged.
- R7: `abs_valid` is high exactly in the cycle after a cycle with `xlat_req` high, and `abs_addr` holds the translation of the address given in that request cycle.
- R8: After reset the block is in narrow mode, the prefix reads zero, `abs_valid` is low, and translation is the identity.
- R9: Without a write and without a mode change, the prefix read-back does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 1 | Requested mode: 0 = narrow (4 KB), 1 = wide (8 KB) |
| pfx_we | input | 1 | Prefix write enable |
| pfx_wdata | input | 64 | Prefix write value, as a byte address |
| xlat_req | input | 1 | Translation request |
| real_addr | input | 64 | Real address to translate |
| abs_valid | output | 1 | Result valid, one cycle after the request |
| abs_addr | output | 64 | Absolute address result |
| pfx_rd | output | 64 | Current prefix as a byte address |
| mode_wide | output | 1 | Current mode |

## Verification
The bench builds the block with its defaults: 64-bit addresses and a 4 KB base granule, so the wide mode uses 8 KB blocks. With these values the full-width top of the address space can be used as a prefix, which exercises the inverse swap at the highest block. Bit 12 is the bit that separates the two modes, so a single-bit difference decides whether an address in the second 4 KB block is remapped or passed through.

// File: rtl/prefix_remap.sv
module prefix_remap #(
  parameter int ADDR_W  = 64,
  parameter int PAGE_LG = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_sel,
  input  logic              pfx_we,
  input  logic [ADDR_W-1:0] pfx_wdata,
  input  logic              xlat_req,
  input  logic [ADDR_W-1:0] real_addr,
  output logic              abs_valid,
  output logic [ADDR_W-1:0] abs_addr,
  output logic [ADDR_W-1:0] pfx_rd,
  output logic              mode_wide
);
  localparam int BLK_W = ADDR_W - PAGE_LG;
  localparam logic [ADDR_W-1:0] NARROW_OFS = (ADDR_W'(1) << PAGE_LG) - ADDR_W'(1);
  localparam logic [ADDR_W-1:0] WIDE_OFS   = (ADDR_W'(1) << (PAGE_LG + 1)) - ADDR_W'(1);

  logic             wide_q;
  logic [BLK_W-1:0] pfx_q;

  wire [ADDR_W-1:0] pfx_addr = {pfx_q, {PAGE_LG{1'b0}}};
  wire [ADDR_W-1:0] ofs_mask = wide_q ? WIDE_OFS : NARROW_OFS;
  wire [ADDR_W-1:0] blk_part = real_addr & ~ofs_mask;
  wire [ADDR_W-1:0] ofs_part = real_addr & ofs_mask;
  wire              hit_low  = (blk_part == '0);
  wire              hit_pfx  = (blk_part == pfx_addr);

  wire [ADDR_W-1:0] xlat = hit_low ? (pfx_addr | ofs_part) :
                           hit_pfx ? ofs_part : real_addr;

  wire [BLK_W-1:0] wr_blk  = pfx_wdata[ADDR_W-1:PAGE_LG];
  wire [BLK_W-1:0] wr_algn = mode_sel ? {wr_blk[BLK_W-1:1], 1'b0} : wr_blk;
  wire [BLK_W-1:0] pfx_nxt = pfx_we ? wr_algn :
                             (mode_sel && !wide_q) ? {pfx_q[BLK_W-1:1], 1'b0} : pfx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wide_q    <= 1'b0;
      pfx_q     <= '0;
      abs_valid <= 1'b0;
      abs_addr  <= '0;
    end else begin
      wide_q    <= mode_sel;
      pfx_q     <= pfx_nxt;
      abs_valid <= xlat_req;
      if (xlat_req) abs_addr <= xlat;
    end
  end

  assign pfx_rd    = pfx_addr;
  assign mode_wide = wide_q;
endmodule

// File: rtl/prefix_remap_chk.sv
module prefix_remap_chk #(
  parameter int ADDR_W  = 64,
  parameter int PAGE_LG = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_sel,
  input logic              pfx_we,
  input logic              xlat_req,
  input logic              abs_valid,
  input logic [ADDR_W-1:0] pfx_rd,
  input logic              mode_wide
);
  a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    xlat_req |=> abs_valid);
  a_r7_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !xlat_req |=> !abs_valid);
  a_r4_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    pfx_rd[PAGE_LG-1:0] == '0);
  a_r5_wide_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wide |-> !pfx_rd[PAGE_LG]);
  a_r9_prefix_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!pfx_we && mode_sel == mode_wide) |=> $stable(pfx_rd));
  a_r6_narrow_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (!pfx_we && mode_wide && !mode_sel) |=> $stable(pfx_rd));
endmodule

bind prefix_remap prefix_remap_chk #(.ADDR_W(ADDR_W), .PAGE_LG(PAGE_LG)) chk_i (
  .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .pfx_we(pfx_we),
  .xlat_req(xlat_req), .abs_valid(abs_valid), .pfx_rd(pfx_rd), .mode_wide(mode_wide)
);

// File: tb/prefix_remap_tb.sv
module prefix_remap_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_sel = 1'b0;
  logic        pfx_we = 1'b0;
  logic [63:0] pfx_wdata = '0;
  logic        xlat_req = 1'b0;
  logic [63:0] real_addr = '0;
  logic        abs_valid;
  logic [63:0] abs_addr;
  logic [63:0] pfx_rd;
  logic        mode_wide;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  prefix_remap dut_i (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .pfx_we(pfx_we),
    .pfx_wdata(pfx_wdata), .xlat_req(xlat_req), .real_addr(real_addr),
    .abs_valid(abs_valid), .abs_addr(abs_addr), .pfx_rd(pfx_rd), .mode_wide(mode_wide)
  );

  // {wide, prefix write, real address, expected absolute}
  localparam int NV = 10;
  localparam logic [192:0] VEC [NV] = '{
    {1'b0, 64'h5000, 64'h0123, 64'h5123},
    {1'b0, 64'h5000, 64'h5FFF, 64'h0FFF},
    {1'b0, 64'h5000, 64'h6000, 64'h6000},
    {1'b0, 64'h5000, 64'h1000, 64'h1000},
    {1'b1, 64'h6000, 64'h1ABC, 64'h7ABC},
    {1'b1, 64'h6000, 64'h7004, 64'h1004},
    {1'b1, 64'h6000, 64'h8000, 64'h8000},
    {1'b0, 64'hFFFF_FFFF_FFFF_F000, 64'h0010, 64'hFFFF_FFFF_FFFF_F010},
    {1'b0, 64'hFFFF_FFFF_FFFF_F000, 64'hFFFF_FFFF_FFFF_F008, 64'h0008},
    {1'b1, 64'h5000, 64'h5000, 64'h1000}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic translate(input logic [63:0] a);
    @(negedge clk);
    xlat_req = 1'b1; real_addr = a;
    @(negedge clk);
    xlat_req = 1'b0;
  endtask

  task automatic write_pfx(input logic wide, input logic [63:0] v);
    @(negedge clk);
    mode_sel = wide; pfx_we = 1'b1; pfx_wdata = v;
    @(negedge clk);
    pfx_we = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8 valid", 64'(abs_valid), 64'h0);
    check("R8 prefix", pfx_rd, 64'h0);
    check("R8 mode", 64'(mode_wide), 64'h0);
    rst_n = 1'b1;
    translate(64'h1234);
    check("R8 identity", abs_addr, 64'h1234);
    check("R7 valid after request", 64'(abs_valid), 64'h1);
    @(negedge clk);
    check("R7 valid drops", 64'(abs_valid), 64'h0);

    for (int i = 0; i < NV; i++) begin
      write_pfx(VEC[i][192], VEC[i][191:128]);
      translate(VEC[i][127:64]);
      check(i < 4 || i == 7 || i == 8 ? "R1/R2/R3 narrow vector" : "R1/R2/R3 wide vector",
            abs_addr, VEC[i][63:0]);
    end
    check("R5 write aligned", pfx_rd, 64'h4000);

    // R4 low bits ignored
    write_pfx(1'b0, 64'h3ABC);
    check("R4 read-back", pfx_rd, 64'h3000);
    // R6 narrow to wide clears bit 12
    @(negedge clk); mode_sel = 1'b1;
    @(negedge clk);
    check("R6 cleared", pfx_rd, 64'h2000);
    check("R6 mode", 64'(mode_wide), 64'h1);
    // R9 prefix holds
    repeat (3) @(negedge clk);
    check("R9 stable", pfx_rd, 64'h2000);
    // R6 wide to narrow keeps
    mode_sel = 1'b0;
    @(negedge clk);
    check("R6 kept", pfx_rd, 64'h2000);
    // R5 write during switch to wide
    write_pfx(1'b0, 64'h7000);
    write_pfx(1'b1, 64'h7000);
    check("R5 switch write", pfx_rd, 64'h6000);
    // R7 request result stays after valid drops
    translate(64'h0FF0);
    check("R1 wide window", abs_addr, 64'h6FF0);
    @(negedge clk);
    check("R7 held", abs_addr, 64'h6FF0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule